// File: doc/BRIEF.md
# System Exception Control Register File

This block is the register front end for the system-level exceptions of a small interrupt controller. Software reaches it over a 32-bit word bus to raise or withdraw the non-maskable, the deferred service and the periodic tick exceptions. It reads back a composed status word that gives the running and the next pending vector. It also holds the relocatable vector table base, a key-guarded reset and active-clear request register, byte-wide priorities for the system handlers, and a handler control word with fault enables.

The block makes no arbitration decisions. The running vector, the highest pending vector, and the per-exception pending and active flags come in as inputs from the controller core. The block turns bus writes into single-cycle set and clear strobes toward that core. A hardware source, such as the tick timer, can raise the tick pending strobe in the same cycle as a bus write. Reads return data one cycle after the access, and accesses to unimplemented offsets raise an error flag in that same response cycle.

Top module: `sysexc_regfile`

## Requirements
- R1: A write to byte offset 0xD04 with bit 31 set drives `nmi_set` high during that write cycle. Otherwise `nmi_set` stays low.
- R2: A write to 0xD04 with bit 28 set drives `dfr_set` in that cycle. Bit 27 drives `dfr_clr` only when bit 28 of the same word is 0, so the two strobes never rise together.
- R3: A write to 0xD04 with bit 26 set drives `tick_set`, and `hw_tick_set` is ORed into `tick_set` in the same cycle. Bit 25 drives `tick_clr` only when bit 26 is 0 and `hw_tick_set` is low.
- R4: The read word of 0xD04 carries the following flags: bit 31 for NMI pending, bit 28 for deferred service pending, bit 26 for tick pending, and bit 22 for any external interrupt pending.
- R5: The read word of 0xD04 holds the running vector in bits 8:0, or 0 when `run_valid` is low. It holds the pending vector in bits 20:12 only when `pend_valid` is high. In both fields, vector numbers of 32 and above are reported minus 16. Bit 11 is set when nothing runs or `run_single` is high.
- R6: The vector base at 0xD08 resets to 0. A write stores bits 31:7 and forces bits 6:0 to 0. A read returns the stored value, and it is also presented on `vt_base`.
- R7: A write to 0xD0C acts only when bits 31:16 equal 0x05FA. With that key, bit 1 pulses `clr_act_req`, and bit 0 or bit 2 pulses `rst_req`, both in the write cycle. A read of 0xD0C returns 0x0FA05000.
- R8: Offsets 0xD18, 0xD1C and 0xD20 each hold four 8-bit priorities in byte lanes 0 to 3. The handler number is the offset minus 0xD14 plus the lane, so handlers 4 to 15 are covered. Byte k of `prio_out` is handler k+4. All priorities reset to 0 and read back as written.
- R9: A read of 0xD24 returns the active flags `hnd_active[6:0]` (memory fault, bus fault, usage fault, supervisor call, debug, deferred service, tick) at bits 0, 1, 3, 7, 8, 10 and 11. It returns the pending flags `hnd_pending[3:0]` (usage, memory, bus, supervisor call) at bits 12 to 15, and the enables at bits 16 to 18. A write to 0xD24 stores bits 18:16 into `fault_en` (memory, bus, usage), which resets to 0.
- R10: Any other offset, or an address with bits 1:0 nonzero, reads as 0, ignores writes and emits no strobe. It drives `bus_err` high in the response cycle, and `bus_err` stays low for implemented offsets.
- R11: Read data and `bus_err` are registered and appear in the cycle after the access. Write strobes are combinational within the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| bus_err | output | 1 | Unimplemented-offset response flag |
| run_valid | input | 1 | A vector is running |
| run_vec | input | 9 | Internal running vector number |
| run_single | input | 1 | Only one active level |
| pend_valid | input | 1 | A vector is pending |
| pend_vec | input | 9 | Internal pending vector number |
| ext_pend_any | input | 1 | Some external interrupt is pending |
| nmi_pend_st | input | 1 | NMI pending state |
| dfr_pend_st | input | 1 | Deferred service pending state |
| tick_pend_st | input | 1 | Tick pending state |
| hw_tick_set | input | 1 | Hardware tick pending request |
| hnd_active | input | 7 | Handler active flags |
| hnd_pending | input | 4 | Fault/supervisor pending flags |
| nmi_set | output | 1 | Set NMI pending |
| dfr_set | output | 1 | Set deferred service pending |
| dfr_clr | output | 1 | Clear deferred service pending |
| tick_set | output | 1 | Set tick pending |
| tick_clr | output | 1 | Clear tick pending |
| clr_act_req | output | 1 | Keyed active-state clear request |
| rst_req | output | 1 | Keyed reset request |
| vt_base | output | 32 | Vector table base |
| fault_en | output | 3 | Fault handler enables |
| prio_out | output | 96 | Handler priorities 4 to 15, one byte each |

## Verification
The tick pending path is the one place where two sources meet in one cycle: a bus write to 0xD04 and the hardware tick request. The bench sweeps all 64 combinations of the five control bits and `hw_tick_set`. For each one it checks in the write cycle that the set side wins over both its own clear bit and the bus clear. The same sweep shows that the deferred service set and clear pair and the NMI set stay independent of the tick pair when they are written in the same word.

// File: rtl/sysexc_pkg.sv
package sysexc_pkg;

    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int VEC_W      = 9;
    localparam int PRIO_WORDS = 3;
    localparam int PRIO_W     = 8;
    localparam int LANES      = DATA_W / PRIO_W;
    localparam int FE_N       = 3;
    localparam int N_ACT      = 7;
    localparam int N_PND      = 4;

    localparam logic [ADDR_W-1:0] OFF_STATUS = 12'hD04;
    localparam logic [ADDR_W-1:0] OFF_VTB    = 12'hD08;
    localparam logic [ADDR_W-1:0] OFF_RST    = 12'hD0C;
    localparam logic [ADDR_W-1:0] OFF_PRIO0  = 12'hD18;
    localparam logic [ADDR_W-1:0] OFF_HCS    = 12'hD24;

    localparam logic [15:0]       RST_KEY    = 16'h05FA;
    localparam logic [DATA_W-1:0] RST_RDVAL  = 32'h0FA0_5000;
    localparam int VTB_LSB = 7;

    localparam int ST_RETBASE = 11;
    localparam int ST_PEND_LSB = 12;
    localparam int ST_EXT  = 22;
    localparam int ST_TICK = 26;
    localparam int ST_DFR  = 28;
    localparam int ST_NMI  = 31;
    localparam int WB_TICK_CLR = 25;
    localparam int WB_DFR_CLR  = 27;
    localparam int FE_LSB = 16;

    localparam int EXT_FIRST = 32;
    localparam int EXT_SHIFT = 16;

    typedef enum logic [2:0] {
        RG_NONE, RG_STATUS, RG_VTB, RG_RST, RG_PRIO, RG_HCS
    } reg_e;

    typedef struct packed {
        reg_e       kind;
        logic [3:0] widx;
        logic       bad;
    } dec_t;

    typedef struct packed {
        logic tick;
        logic dfr;
        logic dbg;
        logic svcall;
        logic usage;
        logic busf;
        logic mem;
    } hact_t;

    typedef struct packed {
        logic svcall;
        logic busf;
        logic mem;
        logic usage;
    } hpnd_t;

    function automatic logic [VEC_W-1:0] vec_report(input logic [VEC_W-1:0] v);
        return (v >= VEC_W'(EXT_FIRST)) ? v - VEC_W'(EXT_SHIFT) : v;
    endfunction

endpackage

// File: rtl/sysexc_decode.sv
module sysexc_decode
    import sysexc_pkg::*;
#(
    parameter int NWORDS = PRIO_WORDS
) (
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] PRIO_END = OFF_PRIO0 + ADDR_W'(4 * NWORDS);

    logic [ADDR_W-1:0] prel;
    assign prel = addr - OFF_PRIO0;

    always_comb begin
        dec      = '0;
        dec.kind = RG_NONE;
        if (sel) begin
            if (addr[1:0] != 2'b00) begin
                dec.bad = 1'b1;
            end else if (addr == OFF_STATUS) begin
                dec.kind = RG_STATUS;
            end else if (addr == OFF_VTB) begin
                dec.kind = RG_VTB;
            end else if (addr == OFF_RST) begin
                dec.kind = RG_RST;
            end else if (addr == OFF_HCS) begin
                dec.kind = RG_HCS;
            end else if (addr >= OFF_PRIO0 && addr < PRIO_END) begin
                dec.kind = RG_PRIO;
                dec.widx = 4'(prel >> 2);
            end else begin
                dec.bad = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sysexc_prio_bank.sv
module sysexc_prio_bank
    import sysexc_pkg::*;
#(
    parameter int NWORDS = PRIO_WORDS,
    parameter int PW     = PRIO_W,
    parameter int NL     = LANES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [3:0]             widx,
    input  logic [DATA_W-1:0]      wdata,
    output logic [NWORDS*NL*PW-1:0] prio_flat,
    output logic [DATA_W-1:0]      rd_word
);
    logic [PW-1:0] pr [NWORDS][NL];

    always_ff @(posedge clk) begin
        for (int w = 0; w < NWORDS; w++) begin
            for (int l = 0; l < NL; l++) begin
                if (rst) begin
                    pr[w][l] <= '0;
                end else if (we && widx == 4'(w)) begin
                    pr[w][l] <= wdata[l*PW +: PW];
                end
            end
        end
    end

    for (genvar gw = 0; gw < NWORDS; gw++) begin : g_word
        for (genvar gl = 0; gl < NL; gl++) begin : g_lane
            assign prio_flat[(gw*NL+gl)*PW +: PW] = pr[gw][gl];
        end
    end

    always_comb begin
        rd_word = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (widx == 4'(w)) begin
                for (int l = 0; l < NL; l++) begin
                    rd_word[l*PW +: PW] = pr[w][l];
                end
            end
        end
    end

    AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(we) |-> $stable(prio_flat)); // R8
endmodule

// File: rtl/sysexc_status.sv
module sysexc_status
    import sysexc_pkg::*;
(
    input  logic              run_valid,
    input  logic [VEC_W-1:0]  run_vec,
    input  logic              run_single,
    input  logic              pend_valid,
    input  logic [VEC_W-1:0]  pend_vec,
    input  logic              ext_pend_any,
    input  logic              nmi_st,
    input  logic              dfr_st,
    input  logic              tick_st,
    input  hact_t             act,
    input  hpnd_t             pnd,
    input  logic [FE_N-1:0]   fen,
    output logic [DATA_W-1:0] stat_word,
    output logic [DATA_W-1:0] hcs_word
);
    always_comb begin
        stat_word = '0;
        if (run_valid) stat_word[VEC_W-1:0] = vec_report(run_vec);
        stat_word[ST_RETBASE] = !run_valid || run_single;
        if (pend_valid) stat_word[ST_PEND_LSB +: VEC_W] = vec_report(pend_vec);
        stat_word[ST_EXT]  = ext_pend_any;
        stat_word[ST_TICK] = tick_st;
        stat_word[ST_DFR]  = dfr_st;
        stat_word[ST_NMI]  = nmi_st;
    end

    always_comb begin
        hcs_word = '0;
        hcs_word[0]  = act.mem;
        hcs_word[1]  = act.busf;
        hcs_word[3]  = act.usage;
        hcs_word[7]  = act.svcall;
        hcs_word[8]  = act.dbg;
        hcs_word[10] = act.dfr;
        hcs_word[11] = act.tick;
        hcs_word[12] = pnd.usage;
        hcs_word[13] = pnd.mem;
        hcs_word[14] = pnd.busf;
        hcs_word[15] = pnd.svcall;
        hcs_word[FE_LSB +: FE_N] = fen;
    end
endmodule

// File: rtl/sysexc_regfile.sv
module sysexc_regfile
    import sysexc_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_sel,
    input  logic                           bus_wr,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    output logic                           bus_err,
    input  logic                           run_valid,
    input  logic [VEC_W-1:0]               run_vec,
    input  logic                           run_single,
    input  logic                           pend_valid,
    input  logic [VEC_W-1:0]               pend_vec,
    input  logic                           ext_pend_any,
    input  logic                           nmi_pend_st,
    input  logic                           dfr_pend_st,
    input  logic                           tick_pend_st,
    input  logic                           hw_tick_set,
    input  logic [N_ACT-1:0]               hnd_active,
    input  logic [N_PND-1:0]               hnd_pending,
    output logic                           nmi_set,
    output logic                           dfr_set,
    output logic                           dfr_clr,
    output logic                           tick_set,
    output logic                           tick_clr,
    output logic                           clr_act_req,
    output logic                           rst_req,
    output logic [DATA_W-1:0]              vt_base,
    output logic [FE_N-1:0]                fault_en,
    output logic [PRIO_WORDS*LANES*PRIO_W-1:0] prio_out
);
    dec_t              dec;
    logic [DATA_W-1:0] stat_word, hcs_word, prio_word, rd_mux;
    logic              wr_stat, wr_key, prio_we;

    sysexc_decode #(.NWORDS(PRIO_WORDS)) u_dec (
        .sel(bus_sel), .addr(bus_addr), .dec(dec)
    );

    sysexc_status u_stat (
        .run_valid(run_valid), .run_vec(run_vec), .run_single(run_single),
        .pend_valid(pend_valid), .pend_vec(pend_vec), .ext_pend_any(ext_pend_any),
        .nmi_st(nmi_pend_st), .dfr_st(dfr_pend_st), .tick_st(tick_pend_st),
        .act(hact_t'(hnd_active)), .pnd(hpnd_t'(hnd_pending)), .fen(fault_en),
        .stat_word(stat_word), .hcs_word(hcs_word)
    );

    assign prio_we = bus_wr && dec.kind == RG_PRIO;

    sysexc_prio_bank #(.NWORDS(PRIO_WORDS), .PW(PRIO_W), .NL(LANES)) u_prio (
        .clk(clk), .rst(rst), .we(prio_we), .widx(dec.widx),
        .wdata(bus_wdata), .prio_flat(prio_out), .rd_word(prio_word)
    );

    // pending control strobes: set side has priority over its clear bit
    assign wr_stat  = bus_wr && dec.kind == RG_STATUS;
    assign nmi_set  = wr_stat && bus_wdata[ST_NMI];
    assign dfr_set  = wr_stat && bus_wdata[ST_DFR];
    assign dfr_clr  = wr_stat && !bus_wdata[ST_DFR] && bus_wdata[WB_DFR_CLR];
    assign tick_set = (wr_stat && bus_wdata[ST_TICK]) || hw_tick_set;
    assign tick_clr = wr_stat && !bus_wdata[ST_TICK] && bus_wdata[WB_TICK_CLR]
                      && !hw_tick_set;

    assign wr_key      = bus_wr && dec.kind == RG_RST && bus_wdata[31:16] == RST_KEY;
    assign clr_act_req = wr_key && bus_wdata[1];
    assign rst_req     = wr_key && (bus_wdata[0] || bus_wdata[2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            vt_base  <= '0;
            fault_en <= '0;
        end else if (bus_wr) begin
            if (dec.kind == RG_VTB)
                vt_base <= {bus_wdata[DATA_W-1:VTB_LSB], VTB_LSB'(0)};
            if (dec.kind == RG_HCS)
                fault_en <= bus_wdata[FE_LSB +: FE_N];
        end
    end

    always_comb begin
        case (dec.kind)
            RG_STATUS: rd_mux = stat_word;
            RG_VTB:    rd_mux = vt_base;
            RG_RST:    rd_mux = RST_RDVAL;
            RG_PRIO:   rd_mux = prio_word;
            RG_HCS:    rd_mux = hcs_word;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_err <= dec.bad;
            if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
        end
    end

    AST_DFR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(dfr_set && dfr_clr)); // R2
    AST_TICK_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(tick_set && tick_clr)); // R3
    AST_HW_TICK: assert property (@(posedge clk) disable iff (rst)
        hw_tick_set |-> tick_set && !tick_clr); // R3
    AST_IDLE_VEC: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == OFF_STATUS && !run_valid)
        |=> bus_rdata[ST_RETBASE] && bus_rdata[VEC_W-1:0] == '0); // R5
    AST_VTB_ALIGN: assert property (@(posedge clk) disable iff (rst)
        vt_base[VTB_LSB-1:0] == '0); // R6
    AST_RST_KEY: assert property (@(posedge clk) disable iff (rst)
        (rst_req || clr_act_req) |-> bus_wdata[31:16] == RST_KEY); // R7
    AST_FE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_sel && bus_wr && bus_addr == OFF_HCS) |-> $stable(fault_en)); // R9
    AST_ERR_AFTER_ACC: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_sel)); // R10
endmodule

// File: tb/sysexc_regfile_tb_top.sv
`timescale 1ns/1ps
module sysexc_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 0, bus_wr = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        run_valid = 0, run_single = 0, pend_valid = 0;
    logic [8:0]  run_vec = '0, pend_vec = '0;
    logic        ext_pend_any = 0, nmi_pend_st = 0, dfr_pend_st = 0, tick_pend_st = 0;
    logic        hw_tick_set = 0;
    logic [6:0]  hnd_active = '0;
    logic [3:0]  hnd_pending = '0;
    logic        nmi_set, dfr_set, dfr_clr, tick_set, tick_clr, clr_act_req, rst_req;
    logic [31:0] vt_base;
    logic [2:0]  fault_en;
    logic [95:0] prio_out;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] rd_val;
    logic        rd_err;
    logic [6:0]  strobes;

    always #2.5 clk = ~clk;

    sysexc_regfile dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .run_valid(run_valid), .run_vec(run_vec), .run_single(run_single),
        .pend_valid(pend_valid), .pend_vec(pend_vec), .ext_pend_any(ext_pend_any),
        .nmi_pend_st(nmi_pend_st), .dfr_pend_st(dfr_pend_st), .tick_pend_st(tick_pend_st),
        .hw_tick_set(hw_tick_set), .hnd_active(hnd_active), .hnd_pending(hnd_pending),
        .nmi_set(nmi_set), .dfr_set(dfr_set), .dfr_clr(dfr_clr), .tick_set(tick_set),
        .tick_clr(tick_clr), .clr_act_req(clr_act_req), .rst_req(rst_req),
        .vt_base(vt_base), .fault_en(fault_en), .prio_out(prio_out)
    );

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // write: strobes captured inside the write cycle, err after the edge
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic hw);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; hw_tick_set = hw;
        #1;
        strobes = {nmi_set, dfr_set, dfr_clr, tick_set, tick_clr, clr_act_req, rst_req};
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; hw_tick_set = 0; bus_wdata = '0;
        rd_err = bus_err;
    endtask

    task automatic bus_read(input logic [11:0] a);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        rd_val = bus_rdata;
        rd_err = bus_err;
    endtask

    function automatic logic [31:0] rep(input int x);
        return 32'((x >= 32) ? x - 16 : x);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] e;
        logic [95:0] prio_snap;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // reset state
        check("R6 reset vt_base", vt_base, 0);
        check("R9 reset fault_en", fault_en, 0);
        check("R8 reset prio", prio_out, 0);

        // R1 R2 R3: all bit patterns plus hardware tick request
        for (int k = 0; k < 64; k++) begin
            logic b31, b28, b27, b26, b25, hw;
            {hw, b25, b26, b27, b28, b31} = 6'(k);
            e = '0;
            e[31] = b31; e[28] = b28; e[27] = b27; e[26] = b26; e[25] = b25;
            bus_write(12'hD04, e, hw);
            check("R1 nmi_set", strobes[6], b31);
            check("R2 dfr_set", strobes[5], b28);
            check("R2 dfr_clr", strobes[4], !b28 && b27);
            check("R3 tick_set", strobes[3], b26 || hw);
            check("R3 tick_clr", strobes[2], !b26 && b25 && !hw);
            check("R10 no err on status write", rd_err, 0);
        end

        // R4 R5: status read sweep over vector numbers and flags
        for (int v = 0; v < 512; v++) begin
            @(negedge clk);
            run_vec = 9'(v); pend_vec = 9'(511 - v);
            run_valid = (v % 3) != 0; pend_valid = (v % 5) != 0;
            run_single = v[3]; ext_pend_any = v[4]; nmi_pend_st = v[5];
            dfr_pend_st = v[6]; tick_pend_st = v[7];
            e = '0;
            if (run_valid) e = e | rep(v);
            if (!run_valid || run_single) e[11] = 1'b1;
            if (pend_valid) e = e | (rep(511 - v) << 12);
            e[22] = ext_pend_any; e[26] = tick_pend_st;
            e[28] = dfr_pend_st; e[31] = nmi_pend_st;
            bus_read(12'hD04);
            check("R4 R5 status word", rd_val, e);
        end

        // R6 vector base
        bus_write(12'hD08, 32'hFFFF_FFFF, 0);
        check("R6 vt_base ones", vt_base, 32'hFFFF_FF80);
        bus_write(12'hD08, 32'h1234_5678, 0);
        bus_read(12'hD08);
        check("R6 vt_base readback", rd_val, 32'h1234_5600);

        // R7 keyed request register
        for (int k = 0; k < 16; k++) begin
            logic [15:0] key;
            key = k[3] ? 16'h05FA : 16'h05FB;
            bus_write(12'hD0C, {key, 13'd0, 3'(k)}, 0);
            check("R7 clr_act_req", strobes[1], k[3] && k[1]);
            check("R7 rst_req", strobes[0], k[3] && (k[0] || k[2]));
        end
        bus_read(12'hD0C);
        check("R7 read constant", rd_val, 32'h0FA0_5000);

        // R8 priority words: handler = offset - 0xD14 + lane
        for (int w = 0; w < 3; w++) begin
            e = '0;
            for (int l = 0; l < 4; l++) e[l*8 +: 8] = 8'(8'hA0 + 4 + 4*w + l);
            bus_write(12'(12'hD18 + 4*w), e, 0);
        end
        for (int h = 4; h < 16; h++)
            check("R8 prio_out byte", prio_out[(h-4)*8 +: 8], 8'(8'hA0 + h));
        for (int w = 0; w < 3; w++) begin
            bus_read(12'(12'hD18 + 4*w));
            e = '0;
            for (int l = 0; l < 4; l++) e[l*8 +: 8] = 8'(8'hA0 + 4 + 4*w + l);
            check("R8 prio readback", rd_val, e);
        end
        bus_write(12'hD1C, 32'h1122_3344, 0);
        check("R8 word1 rewritten", prio_out[63:32], 32'h1122_3344);
        check("R8 word0 untouched", prio_out[31:0], 32'hA7A6_A5A4);
        check("R8 word2 untouched", prio_out[95:64], 32'hAFAE_ADAC);

        // R9 handler control word
        bus_write(12'hD24, 32'h0005_0000, 0);
        check("R9 fault_en write", fault_en, 3'b101);
        for (int k = 0; k < 2048; k++) begin
            @(negedge clk);
            hnd_active = k[6:0]; hnd_pending = k[10:7];
            e = '0;
            e[0] = k[0]; e[1] = k[1]; e[3] = k[2]; e[7] = k[3];
            e[8] = k[4]; e[10] = k[5]; e[11] = k[6];
            e[15:12] = {k[10], k[9], k[8], k[7]} & 4'hF;
            e[12] = k[7]; e[13] = k[8]; e[14] = k[9]; e[15] = k[10];
            e[18:16] = 3'b101;
            bus_read(12'hD24);
            check("R9 hcs word", rd_val, e);
        end
        check("R10 no err on hcs read", rd_err, 0);

        // R10 unimplemented offsets; R11 registered response
        prio_snap = prio_out;
        begin
            logic [11:0] bad [7];
            bad = '{12'h000, 12'hD00, 12'hD10, 12'hD14, 12'hD28, 12'hD06, 12'hFFC};
            for (int i = 0; i < 7; i++) begin
                bus_read(bad[i]);
                check("R10 bad read data", rd_val, 0);
                check("R10 R11 bad read err", rd_err, 1);
                bus_write(bad[i], 32'hFFFF_FFFF, 0);
                check("R10 bad write strobes", strobes, 0);
                check("R10 bad write err", rd_err, 1);
                check("R10 vt_base kept", vt_base, 32'h1234_5600);
                check("R10 fault_en kept", fault_en, 3'b101);
                check("R10 prio kept", prio_out, prio_snap);
            end
        end
        @(negedge clk);
        check("R10 err drops", bus_err, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule